// File: doc/BRIEF.md
# Receive Framer Performance Monitor

This block sits behind a T1 receive framer and turns its single-cycle event strobes into performance statistics. Framing bit errors, CRC-6 mismatches, losses of frame synchronisation and shifts of the frame alignment each drive their own counter. A fifth counter measures time rather than events. While basic frame sync is lost, it advances once per multiframe period, which is 1.5 ms in D4 mode and 3 ms in ESF mode, measured in ticks of a timebase input.

A one-second tick copies every running counter into a latched copy and restarts the running counter in the same cycle. Each latch therefore always holds a full second's total. Qualified events also set sticky status bits. Software clears a status bit by writing 1 to it. A mask register, active low, selects which status bits raise the interrupt. All counters, latches, the status and the mask are reached through a small register port with a combinational read path.

Top module: `framer_perf_mon`

## Requirements
- R1: After reset every running counter, every latched copy and the status register read 0, the mask reads all ones, and `irq` is low.
- R2: The framing-bit counter (address 0) adds one for `ft_err` and, only when `mode_esf` is 0 (D4), one more for `fs_err` in the same cycle. In ESF mode `fs_err` has no effect.
- R3: The CRC-6 counter (address 1) adds one per `crc_err` strobe while `mode_esf` is 1. While `mode_esf` is 0 the strobe has no effect.
- R4: The out-of-frame counter (address 2) adds one per `sync_loss` strobe. The change-of-frame counter (address 3) adds one per `align_chg` strobe.
- R5: While `sync_lost` is high, the out-of-multiframe counter (address 4) adds one on every HALF_MF-th `tb_tick` in D4 mode and on every 2*HALF_MF-th tick in ESF mode. While `sync_lost` is low, the interval timer is held at its start, so each loss of sync begins a fresh interval.
- R6: Every counter stops at 2^CNT_W-1 and does not wrap.
- R7: In a cycle with `sec_tick` high, each latched copy (addresses 5 to 9, in the same order as addresses 0 to 4) takes the running value from before that cycle. The running counter restarts at the increment of that cycle alone.
- R8: The status register (address 10) has bit 0 for a counted framing error, bit 1 for a counted CRC-6 error, bit 2 for sync loss, bit 3 for an alignment change and bit 4 for an out-of-multiframe increment. Each bit is set the cycle after its event and stays set.
- R9: Writing to address 10 clears each status bit written as 1. An event in the same cycle keeps its bit set.
- R10: The mask register (address 11) is read/write and resets to all ones. `irq` is high exactly when some status bit has a 0 in the matching bit of the mask.
- R11: Reads are combinational from `reg_addr`. Addresses 12 to 15 read 0, and writes to any address other than 10 and 11 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_esf | input | 1 | 1 selects ESF, 0 selects D4 |
| ft_err | input | 1 | Terminal framing bit error strobe |
| fs_err | input | 1 | Signalling framing bit error strobe |
| crc_err | input | 1 | CRC-6 mismatch strobe |
| sync_loss | input | 1 | Loss of frame sync strobe |
| align_chg | input | 1 | Frame alignment shift strobe |
| sync_lost | input | 1 | Level, high while basic frame sync is absent |
| tb_tick | input | 1 | Timebase tick, HALF_MF ticks per 1.5 ms |
| sec_tick | input | 1 | One-second snapshot strobe |
| reg_addr | input | 4 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | CNT_W | Register write data |
| reg_rdata | output | CNT_W | Register read data |
| irq | output | 1 | Interrupt request, active high |

## Verification
The hardest case to reach is the out-of-multiframe interval under disturbance. This covers a mode switch in the middle of an interval, a drop of `sync_lost` one tick before the interval ends, and a counter already at its ceiling when a one-second tick lands. The stimulus holds `sync_lost` for long random stretches with sparse timebase ticks, and it flips `mode_esf` and `sec_tick` independently. A saturation phase drives both framing strobes continuously for hundreds of cycles. Every cycle the bench walks `reg_addr` through the whole map and compares each read and `irq` against its behavioural model.

// File: rtl/framer_perf_mon.sv
module framer_perf_mon #(
  parameter int CNT_W   = 8,
  parameter int HALF_MF = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_esf,
  input  logic             ft_err,
  input  logic             fs_err,
  input  logic             crc_err,
  input  logic             sync_loss,
  input  logic             align_chg,
  input  logic             sync_lost,
  input  logic             tb_tick,
  input  logic             sec_tick,
  input  logic [3:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [CNT_W-1:0] reg_wdata,
  output logic [CNT_W-1:0] reg_rdata,
  output logic             irq
);
  localparam int NC = 5;
  localparam int SW = 5;
  localparam int PW = $clog2(2 * HALF_MF + 1);
  localparam logic [CNT_W-1:0] CMAX = {CNT_W{1'b1}};
  localparam logic [PW-1:0] PER_D4  = PW'(HALF_MF);
  localparam logic [PW-1:0] PER_ESF = PW'(2 * HALF_MF);
  localparam logic [3:0] A_STAT = 4'd10;
  localparam logic [3:0] A_MASK = 4'd11;

  logic [CNT_W-1:0] cnt [NC];
  logic [CNT_W-1:0] lat [NC];
  logic [1:0]       inc [NC];
  logic [SW-1:0]    status, ev_set, ev_clr;
  logic [CNT_W-1:0] mask;
  logic [PW-1:0]    tmr, period;
  logic             mf_fire;

  assign period  = mode_esf ? PER_ESF : PER_D4;
  assign mf_fire = sync_lost && tb_tick && (tmr >= period - PW'(1));

  assign inc[0] = {1'b0, ft_err} + {1'b0, fs_err && !mode_esf};
  assign inc[1] = {1'b0, crc_err && mode_esf};
  assign inc[2] = {1'b0, sync_loss};
  assign inc[3] = {1'b0, align_chg};
  assign inc[4] = {1'b0, mf_fire};

  assign ev_set = {mf_fire, align_chg, sync_loss, inc[1][0], inc[0] != 2'd0};
  assign ev_clr = (reg_wr && reg_addr == A_STAT) ? reg_wdata[SW-1:0] : '0;

  function automatic logic [CNT_W-1:0] sat_add(input logic [CNT_W-1:0] a, input logic [1:0] b);
    logic [CNT_W:0] s;
    s = {1'b0, a} + (CNT_W+1)'(b);
    return s[CNT_W] ? CMAX : s[CNT_W-1:0];
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
    end else if (!sync_lost || mf_fire) begin
      tmr <= '0;
    end else if (tb_tick) begin
      tmr <= tmr + PW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NC; i++) begin
        cnt[i] <= '0;
        lat[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NC; i++) begin
        if (sec_tick) begin
          lat[i] <= cnt[i];
          cnt[i] <= sat_add('0, inc[i]);
        end else begin
          cnt[i] <= sat_add(cnt[i], inc[i]);
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '1;
    end else begin
      status <= (status & ~ev_clr) | ev_set;
      if (reg_wr && reg_addr == A_MASK) mask <= reg_wdata;
    end
  end

  assign irq = |(status & ~mask[SW-1:0]);

  always_comb begin
    reg_rdata = '0;
    if (reg_addr < 4'd5)          reg_rdata = cnt[reg_addr];
    else if (reg_addr < 4'd10)    reg_rdata = lat[reg_addr - 4'd5];
    else if (reg_addr == A_STAT)  reg_rdata = CNT_W'(status);
    else if (reg_addr == A_MASK)  reg_rdata = mask;
  end

  p_fbe_mono_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sec_tick) |-> cnt[0] >= $past(cnt[0]));

  p_lat_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sec_tick) |-> $stable(lat[2]));

  p_lat_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sec_tick) |-> lat[1] == $past(cnt[1]));

  p_mf_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(sync_lost) && !$past(sec_tick)) |-> $stable(cnt[4]));

  p_crc_d4_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(mode_esf) && !$past(sec_tick)) |-> $stable(cnt[1]));

  p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !($past(reg_wr) && $past(reg_addr) == A_STAT) |-> (status & $past(status)) == $past(status));

  p_oof_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sec_tick) |-> cnt[2] - $past(cnt[2]) <= CNT_W'(1));
endmodule

// File: tb/test_framer_perf_mon.sv
`timescale 1ns/1ps
module test_framer_perf_mon;
  localparam int W = 8;
  localparam int HALF = 3;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 0, rst_n = 0;
  logic mode_esf = 0, ft_err = 0, fs_err = 0, crc_err = 0, sync_loss = 0, align_chg = 0;
  logic sync_lost = 0, tb_tick = 0, sec_tick = 0, reg_wr = 0, irq;
  logic [3:0] reg_addr = 0;
  logic [W-1:0] reg_wdata = 0, reg_rdata;

  int checks = 0, errors = 0;
  bit done = 0;
  string phase = "R1";

  framer_perf_mon #(.CNT_W(W), .HALF_MF(HALF)) i_framer_perf_mon (
    .clk(clk), .rst_n(rst_n), .mode_esf(mode_esf), .ft_err(ft_err), .fs_err(fs_err),
    .crc_err(crc_err), .sync_loss(sync_loss), .align_chg(align_chg), .sync_lost(sync_lost),
    .tb_tick(tb_tick), .sec_tick(sec_tick), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #2.5 clk = ~clk;

  int m_cnt[5], m_lat[5], m_st, m_mk, m_tmr;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_cnt[i]) begin m_cnt[i] = 0; m_lat[i] = 0; end
      m_st = 0; m_mk = MAXV; m_tmr = 0;
    end else begin
      int inc[5];
      int per;
      int clr;
      inc[0] = ft_err + ((!mode_esf && fs_err) ? 1 : 0);
      inc[1] = (mode_esf && crc_err) ? 1 : 0;
      inc[2] = sync_loss;
      inc[3] = align_chg;
      inc[4] = 0;
      per = mode_esf ? 2 * HALF : HALF;
      if (!sync_lost) m_tmr = 0;
      else if (tb_tick) begin
        if (m_tmr + 1 >= per) begin m_tmr = 0; inc[4] = 1; end
        else m_tmr = m_tmr + 1;
      end
      for (int i = 0; i < 5; i++) begin
        if (sec_tick) begin
          m_lat[i] = m_cnt[i];
          m_cnt[i] = (inc[i] > MAXV) ? MAXV : inc[i];
        end else begin
          m_cnt[i] = (m_cnt[i] + inc[i] > MAXV) ? MAXV : m_cnt[i] + inc[i];
        end
      end
      clr = (reg_wr && reg_addr == 10) ? (reg_wdata & 31) : 0;
      m_st = (m_st & ~clr) | (inc[0] != 0 ? 1 : 0) | (inc[1] << 1) | (inc[2] << 2)
             | (inc[3] << 3) | (inc[4] << 4);
      if (reg_wr && reg_addr == 11) m_mk = reg_wdata;
    end
  end

  function automatic int model_rd(int a);
    if (a < 5) return m_cnt[a];
    if (a < 10) return m_lat[a - 5];
    if (a == 10) return m_st;
    if (a == 11) return m_mk;
    return 0;
  endfunction

  function automatic string addr_req(int a);
    if (a == 0) return "R2";
    if (a == 1) return "R3";
    if (a < 4) return "R4";
    if (a == 4) return "R5";
    if (a < 10) return "R7";
    if (a == 10) return "R8";
    if (a == 11) return "R10";
    return "R11";
  endfunction

  task automatic compare();
    int exp_rd;
    bit exp_irq;
    exp_rd = model_rd(reg_addr);
    exp_irq = ((m_st & ~m_mk & 31) != 0);
    checks++;
    if (reg_rdata !== W'(exp_rd)) begin
      errors++;
      $display("FAIL %s/%s addr %0d rdata %0d expected %0d", phase, addr_req(reg_addr), reg_addr, reg_rdata, exp_rd);
    end
    checks++;
    if (irq !== exp_irq) begin
      errors++;
      $display("FAIL %s/R10 irq %0b expected %0b", phase, irq, exp_irq);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    compare();
    reg_addr = reg_addr + 4'd1;
    reg_wr = 0;
    sec_tick = 0;
  endtask

  task automatic rand_events(int n, int p_ev, int p_tick, int p_sec);
    for (int k = 0; k < n; k++) begin
      ft_err    = ($urandom_range(99) < p_ev);
      fs_err    = ($urandom_range(99) < p_ev);
      crc_err   = ($urandom_range(99) < p_ev);
      sync_loss = ($urandom_range(99) < p_ev);
      align_chg = ($urandom_range(99) < p_ev);
      tb_tick   = ($urandom_range(99) < p_tick);
      sec_tick  = ($urandom_range(99) < p_sec);
      cyc();
    end
    {ft_err, fs_err, crc_err, sync_loss, align_chg, tb_tick} = '0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    phase = "R1";
    for (int a = 0; a < 16; a++) begin reg_addr = 4'(a); #0.1; compare(); end
    rst_n = 1;
    for (int a = 0; a < 16; a++) cyc();

    phase = "R2";  mode_esf = 0; rand_events(300, 30, 0, 0);
    phase = "R3";  mode_esf = 1; rand_events(300, 30, 0, 0);
    phase = "R7";  mode_esf = 0; rand_events(300, 20, 0, 5);

    phase = "R5";
    for (int r = 0; r < 12; r++) begin
      mode_esf = r[0];
      sync_lost = 1;
      rand_events(40 + 7 * r, 0, 40, 2);
      if (r == 5) mode_esf = ~mode_esf;
      rand_events(10, 0, 50, 0);
      sync_lost = 0;
      rand_events(5, 0, 50, 0);
    end

    phase = "R6";
    sec_tick = 1; cyc();
    mode_esf = 0; sync_lost = 1;
    for (int k = 0; k < 320; k++) begin
      ft_err = 1; fs_err = 1; sync_loss = 1; align_chg = 1; tb_tick = 1;
      crc_err = 1; mode_esf = k[5];
      cyc();
    end
    {ft_err, fs_err, crc_err, sync_loss, align_chg, tb_tick, sync_lost} = '0;
    for (int k = 0; k < 32; k++) cyc();
    sec_tick = 1; cyc();
    for (int k = 0; k < 32; k++) cyc();

    phase = "R9";
    for (int k = 0; k < 200; k++) begin
      ft_err = ($urandom_range(9) == 0);
      align_chg = ($urandom_range(9) == 0);
      sync_lost = ($urandom_range(3) != 0);
      tb_tick = 1;
      if ($urandom_range(2) == 0) begin
        reg_addr = 4'd10; reg_wr = 1; reg_wdata = W'($urandom_range(MAXV));
      end
      cyc();
    end
    {ft_err, align_chg, sync_lost, tb_tick} = '0;

    phase = "R10";
    for (int k = 0; k < 120; k++) begin
      if (k % 8 == 0) begin reg_addr = 4'd11; reg_wr = 1; reg_wdata = W'($urandom_range(MAXV)); end
      else if (k % 8 == 3) begin reg_addr = 4'd10; reg_wr = 1; reg_wdata = W'($urandom_range(31)); end
      sync_loss = ($urandom_range(5) == 0);
      crc_err = ($urandom_range(5) == 0);
      mode_esf = 1;
      cyc();
    end
    {sync_loss, crc_err} = '0;

    phase = "R11";
    for (int k = 0; k < 64; k++) begin
      reg_addr = 4'($urandom_range(15));
      if (reg_addr != 4'd10 && reg_addr != 4'd11) begin reg_wr = 1; reg_wdata = W'($urandom_range(MAXV)); end
      cyc();
    end
    for (int k = 0; k < 16; k++) cyc();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule